// File: doc/BRIEF.md
# ADC Conversion Status Flag Controller

This block keeps the event flags of an analog-to-digital converter that has a regular conversion path and an injected, higher-priority conversion path. The conversion engine pulses one input per event: a regular result is ready, an injected result is ready (together with the index of the injected result slot it went to), the sampling phase has ended, the regular sequence has ended, or the injected sequence has ended. Each pulse sets a sticky flag. The flag stays set until software clears it.

Software reaches the block through a simple word-addressed read/write port. Writing 1 to a flag bit in the status word clears that flag. The regular-result flag is also cleared when the regular data word is read. The injected-result flag is also cleared when an injected data word is read, but only if that word is the slot that received the most recent injected result. The data words themselves are served by the conversion engine. This block only watches those reads. Each flag has an enable bit, and one combined interrupt output is raised while any enabled flag is set.

Top module: `adc_evflag_ctrl`

## Requirements
- R1: After a synchronous reset, the status word and the enable word read as 0, `irq` is low, and the latest injected slot is 0.
- R2: A pulse on an event input sets its flag from the next clock edge on, and the flag stays set. Flag bit positions in the status word are: 0 regular result, 1 injected result, 2 end of sampling, 3 end of regular sequence, 4 end of injected sequence.
- R3: A write to the status word (address 0) clears every flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R4: A read of the regular data word (address 2) clears the regular-result flag (bit 0).
- R5: A read of injected data word k (address 3+k, k = 0..3) clears the injected-result flag (bit 1) only when k equals the slot given with the latest injected-result pulse. A read of any other slot has no effect.
- R6: When a set pulse and a clear (by write or by read) reach the same flag in the same cycle, the flag ends up set.
- R7: The enable word (address 1, bits 4:0 in the R2 order) can be written and read back. `irq` is high exactly when some flag and its enable bit are both 1, and it follows the registered flags and enables with no extra delay.
- R8: A read of the status word or the enable word clears no flag.
- R9: The end-of-sampling and both end-of-sequence flags are cleared only by a write-1. No data-word read changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_reg_done | input | 1 | Regular result is ready in the regular data word |
| evt_inj_done | input | 1 | Injected result is ready in one injected data word |
| evt_inj_slot | input | SLOT_W | Index of the injected data word written with `evt_inj_done` |
| evt_smp_end | input | 1 | Sampling phase of a regular conversion has ended |
| evt_reg_seq_end | input | 1 | Last result of the regular sequence is ready |
| evt_inj_seq_end | input | 1 | Injected sequence has completed |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the status and enable words, 0 for any other address |
| irq | output | 1 | Combined interrupt |

## Verification
A pulse or bus access in cycle n affects the flags from the edge that ends cycle n. So the effect of an event or a clear is first seen in cycle n+1, both in `irq` and in the status word. Read data is combinational from the registered state, so it shows the state as it was before the edge of the access cycle. The bench drives every input at the falling edge. It checks `bus_rdata` one nanosecond later in the same cycle and compares `irq` on every falling edge against a reference model. The model applies each cycle's stimulus at the rising edge, so each comparison lands on the cycle where the result is due. Same-cycle set and clear, reads of a stale injected slot, and zero-bit writes are each driven on their own and then read back through the status word.

// File: rtl/adc_evflag_pkg.sv
package adc_evflag_pkg;

    localparam int NFLAG = 5;

    // Flag bit positions, shared by the status and enable words
    localparam int F_REOC = 0;
    localparam int F_IEOC = 1;
    localparam int F_SMP  = 2;
    localparam int F_RSEQ = 3;
    localparam int F_ISEQ = 4;

    // Word addresses
    localparam int A_STS   = 0;
    localparam int A_IEN   = 1;
    localparam int A_RDAT  = 2;
    localparam int A_IDAT0 = 3;

    typedef logic [NFLAG-1:0] flag_vec_t;

    // Hardware events, packed so that the bit order matches the flag positions
    typedef struct packed {
        logic iseq;
        logic rseq;
        logic smp;
        logic ieoc;
        logic reoc;
    } evt_t;

    // One cycle of decoded bus activity
    typedef struct packed {
        flag_vec_t w1c;
        flag_vec_t rdclr;
        logic      en_we;
    } bus_op_t;

    function automatic logic any_pending(flag_vec_t f, flag_vec_t e);
        return |(f & e);
    endfunction

endpackage

// File: rtl/evflag_decode.sv
module evflag_decode
    import adc_evflag_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 32,
    parameter int NUM_INJ = 4,
    parameter int SLOT_W  = 2
) (
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SLOT_W-1:0] last_slot,
    output bus_op_t           op
);
    localparam int INJ_END = A_IDAT0 + NUM_INJ;

    logic              in_inj;
    logic [ADDR_W-1:0] inj_off;
    logic              inj_hit;

    assign in_inj  = (int'(addr) >= A_IDAT0) && (int'(addr) < INJ_END);
    assign inj_off = addr - ADDR_W'(A_IDAT0);
    assign inj_hit = rd && in_inj && (inj_off == ADDR_W'(last_slot));

    always_comb begin
        op = '0;
        if (wr && addr == ADDR_W'(A_STS)) begin
            op.w1c = wdata[NFLAG-1:0];
        end
        op.en_we = wr && (addr == ADDR_W'(A_IEN));
        op.rdclr[F_REOC] = rd && (addr == ADDR_W'(A_RDAT));
        op.rdclr[F_IEOC] = inj_hit;
    end
endmodule

// File: rtl/evflag_cell.sv
module evflag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (set) begin
            q <= 1'b1;
        end else if (clr) begin
            q <= 1'b0;
        end
    end
endmodule

// File: rtl/evflag_slot_track.sv
module evflag_slot_track #(
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic [SLOT_W-1:0] slot_in,
    output logic [SLOT_W-1:0] slot_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (upd) begin
            slot_q <= slot_in;
        end
    end
endmodule

// File: rtl/adc_evflag_ctrl.sv
module adc_evflag_ctrl
    import adc_evflag_pkg::*;
#(
    parameter  int NUM_INJ = 4,
    parameter  int ADDR_W  = 3,
    parameter  int DATA_W  = 32,
    localparam int SLOT_W  = (NUM_INJ > 1) ? $clog2(NUM_INJ) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_reg_done,
    input  logic              evt_inj_done,
    input  logic [SLOT_W-1:0] evt_inj_slot,
    input  logic              evt_smp_end,
    input  logic              evt_reg_seq_end,
    input  logic              evt_inj_seq_end,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    evt_t              evt;
    bus_op_t           op;
    flag_vec_t         flags;
    flag_vec_t         en_q;
    flag_vec_t         clr;
    logic [SLOT_W-1:0] last_slot;

    assign evt.reoc = evt_reg_done;
    assign evt.ieoc = evt_inj_done;
    assign evt.smp  = evt_smp_end;
    assign evt.rseq = evt_reg_seq_end;
    assign evt.iseq = evt_inj_seq_end;

    evflag_slot_track #(.SLOT_W(SLOT_W)) u_slot (
        .clk     (clk),
        .rst     (rst),
        .upd     (evt_inj_done),
        .slot_in (evt_inj_slot),
        .slot_q  (last_slot)
    );

    evflag_decode #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .NUM_INJ (NUM_INJ),
        .SLOT_W  (SLOT_W)
    ) u_dec (
        .wr        (bus_wr),
        .rd        (bus_rd),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .last_slot (last_slot),
        .op        (op)
    );

    assign clr = op.w1c | op.rdclr;

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        evflag_cell u_cell (
            .clk (clk),
            .rst (rst),
            .set (evt[i]),
            .clr (clr[i]),
            .q   (flags[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (op.en_we) begin
            en_q <= bus_wdata[NFLAG-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_STS)) begin
            bus_rdata[NFLAG-1:0] = flags;
        end else if (bus_addr == ADDR_W'(A_IEN)) begin
            bus_rdata[NFLAG-1:0] = en_q;
        end
    end

    assign irq = any_pending(flags, en_q);

endmodule

// File: rtl/evflag_chk.sv
module evflag_chk
    import adc_evflag_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input flag_vec_t         evt,
    input logic              wr,
    input logic              rd,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input flag_vec_t         flags,
    input flag_vec_t         en,
    input logic              irq
);
    for (genvar k = 0; k < NFLAG; k++) begin : g_chk
        // R2
        evt_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
            evt[k] |=> flags[k]);
        // R3
        w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
            (wr && addr == ADDR_W'(A_STS) && wdata[k] && !evt[k]) |=> !flags[k]);
        // R3
        zero_write_keeps_chk: assert property (@(posedge clk) disable iff (rst)
            (wr && addr == ADDR_W'(A_STS) && !wdata[k] && flags[k]) |=> flags[k]);
        // R8
        ctl_read_keeps_chk: assert property (@(posedge clk) disable iff (rst)
            (rd && (addr == ADDR_W'(A_STS) || addr == ADDR_W'(A_IEN)) && flags[k]) |=> flags[k]);
        // R7
        enabled_flag_irq_chk: assert property (@(posedge clk) disable iff (rst)
            (flags[k] && en[k]) |-> irq);
    end

    // R7
    idle_irq_low_chk: assert property (@(posedge clk) disable iff (rst)
        (flags == '0) |-> !irq);

    // R4
    rdat_read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == ADDR_W'(A_RDAT) && !evt[F_REOC]) |=> !flags[F_REOC]);

    // R9
    seq_flags_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr && flags[F_SMP] && flags[F_RSEQ] && flags[F_ISEQ])
            |=> (flags[F_SMP] && flags[F_RSEQ] && flags[F_ISEQ]));
endmodule

bind adc_evflag_ctrl evflag_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .evt   ({evt_inj_seq_end, evt_reg_seq_end, evt_smp_end, evt_inj_done, evt_reg_done}),
    .wr    (bus_wr),
    .rd    (bus_rd),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .flags (flags),
    .en    (en_q),
    .irq   (irq)
);

// File: tb/tb_adc_evflag_ctrl.sv
module tb_adc_evflag_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_reg_done = 0, evt_inj_done = 0, evt_smp_end = 0;
    logic        evt_reg_seq_end = 0, evt_inj_seq_end = 0;
    logic [1:0]  evt_inj_slot = '0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;

    // behavioural reference state
    bit [4:0] m_flag = '0;
    bit [4:0] m_en   = '0;
    int       m_slot = 0;

    always #4 clk = ~clk;

    adc_evflag_ctrl dut (
        .clk(clk), .rst(rst),
        .evt_reg_done(evt_reg_done), .evt_inj_done(evt_inj_done),
        .evt_inj_slot(evt_inj_slot), .evt_smp_end(evt_smp_end),
        .evt_reg_seq_end(evt_reg_seq_end), .evt_inj_seq_end(evt_inj_seq_end),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_flag = '0; m_en = '0; m_slot = 0;
        end else begin
            bit [4:0] ev;
            bit [4:0] kill;
            ev = {evt_inj_seq_end, evt_reg_seq_end, evt_smp_end, evt_inj_done, evt_reg_done};
            kill = '0;
            if (bus_wr && bus_addr == 3'd0) kill = bus_wdata[4:0];
            if (bus_rd && bus_addr == 3'd2) kill[0] = 1'b1;
            if (bus_rd && bus_addr >= 3'd3 && int'(bus_addr) - 3 == m_slot) kill[1] = 1'b1;
            for (int i = 0; i < 5; i++) begin
                if (ev[i]) m_flag[i] = 1'b1;
                else if (kill[i]) m_flag[i] = 1'b0;
            end
            if (bus_wr && bus_addr == 3'd1) m_en = bus_wdata[4:0];
            if (evt_inj_done) m_slot = int'(evt_inj_slot);
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R7: irq compared every cycle
    always @(negedge clk) begin
        if (!rst) check("R7 irq", {31'd0, irq}, {31'd0, |(m_flag & m_en)});
    end

    // one bus/event cycle; rdata checked for status/enable reads
    task automatic cyc(input bit [4:0] ev, input int slot, input bit wr, input bit rd,
                       input int addr, input int wdata, input string tag);
        @(negedge clk);
        {evt_inj_seq_end, evt_reg_seq_end, evt_smp_end, evt_inj_done, evt_reg_done} = ev;
        evt_inj_slot = 2'(slot);
        bus_wr = wr; bus_rd = rd; bus_addr = 3'(addr); bus_wdata = 32'(wdata);
        #1;
        if (rd && addr == 0) check(tag, bus_rdata, {27'd0, m_flag});
        if (rd && addr == 1) check(tag, bus_rdata, {27'd0, m_en});
    endtask

    task automatic idle();
        cyc(5'b0, 0, 0, 0, 0, 0, "");
    endtask

    task automatic rd_sts(input string tag);
        cyc(5'b0, 0, 0, 1, 0, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1 reset state
        rd_sts("R1 status after reset");
        check("R1 status zero", bus_rdata, 32'd0);
        cyc(5'b0, 0, 0, 1, 1, 0, "R1 enable after reset");
        check("R1 irq low", {31'd0, irq}, 32'd0);
        // R2 each event alone
        for (int i = 0; i < 5; i++) begin
            cyc(5'(1 << i), 1, 0, 0, 0, 0, "");
            rd_sts("R2 event sets flag");
        end
        check("R2 all flags set", bus_rdata, 32'h1f);
        idle(); rd_sts("R2 flags sticky");
        // R3 zero write, then single-bit write
        cyc(5'b0, 0, 1, 0, 0, 32'h0, "");
        rd_sts("R3 zero write keeps flags");
        check("R3 still 1f", bus_rdata, 32'h1f);
        cyc(5'b0, 0, 1, 0, 0, 32'h04, "");
        rd_sts("R3 bit 2 cleared");
        check("R3 value 1b", bus_rdata, 32'h1b);
        // R8 control reads do not clear
        rd_sts("R8 status read"); rd_sts("R8 status reread");
        cyc(5'b0, 0, 0, 1, 1, 0, "R8 enable read");
        rd_sts("R8 flags intact");
        // R4 / R9 regular data read
        cyc(5'b0, 0, 0, 1, 2, 0, "");
        rd_sts("R4 reg data read clears bit0");
        check("R4 value 1a", bus_rdata, 32'h1a);
        for (int k = 0; k < 4; k++) cyc(5'b0, 0, 0, 1, 3 + k, 0, "");
        cyc(5'b0, 0, 0, 1, 2, 0, "");
        rd_sts("R9 seq/smp flags survive data reads");
        check("R9 bits 3 and 4 kept", {27'd0, bus_rdata[4:3], 3'd0}, 32'h18);
        // R5 latest slot only
        cyc(5'b00010, 2, 0, 0, 0, 0, "");
        cyc(5'b0, 0, 0, 1, 4, 0, "");
        rd_sts("R5 stale slot read keeps bit1");
        check("R5 bit1 kept", {30'd0, bus_rdata[1], 1'b0}, 32'h2);
        cyc(5'b0, 0, 0, 1, 5, 0, "");
        rd_sts("R5 latest slot read clears bit1");
        check("R5 bit1 cleared", {30'd0, bus_rdata[1], 1'b0}, 32'h0);
        cyc(5'b00010, 3, 0, 0, 0, 0, "");
        cyc(5'b0, 0, 0, 1, 5, 0, "");
        rd_sts("R5 old slot no longer clears");
        cyc(5'b0, 0, 0, 1, 6, 0, "");
        rd_sts("R5 new slot clears");
        // R6 set wins over write-1 and over read-clear
        cyc(5'b00001, 0, 1, 0, 0, 32'h1, "");
        rd_sts("R6 set beats write-1");
        check("R6 bit0 set", {31'd0, bus_rdata[0]}, 32'd1);
        cyc(5'b00001, 0, 0, 1, 2, 0, "");
        rd_sts("R6 set beats data read");
        check("R6 bit0 still set", {31'd0, bus_rdata[0]}, 32'd1);
        cyc(5'b10000, 0, 1, 0, 0, 32'h10, "");
        rd_sts("R6 seq set beats write-1");
        // R7 enable word and irq
        cyc(5'b0, 0, 1, 0, 1, 32'h04, "");
        cyc(5'b0, 0, 0, 1, 1, 0, "R7 enable readback");
        check("R7 enable value", bus_rdata, 32'h04);
        check("R7 irq low (flag 2 clear)", {31'd0, irq}, 32'd0);
        cyc(5'b00100, 0, 0, 0, 0, 0, "");
        idle();
        check("R7 irq high", {31'd0, irq}, 32'd1);
        cyc(5'b0, 0, 1, 0, 0, 32'h04, "");
        idle();
        check("R7 irq low after clear", {31'd0, irq}, 32'd0);
        cyc(5'b0, 0, 1, 0, 1, 32'h1f, "");
        idle();
        cyc(5'b0, 0, 1, 0, 0, 32'h1f, "");
        idle();
        rd_sts("R3 all cleared");
        check("R3 zero", bus_rdata, 32'd0);
        repeat (3) idle();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule